// File: doc/BRIEF.md
# Power Management Control and Status Register

This block is the 16-bit power management control/status word of one bus function. A simple address/data port reaches it at a fixed offset. It holds three pieces of state: the function's power state, an enable for the power-management event (PME) signal, and a sticky PME status flag. Two synchronous reset inputs clear different bits. The global reset clears everything. The primary bus reset leaves the enable alone. It clears the status flag only while the enable is low.

A PME event input sets the status flag whether the event is enabled or not. The PME output is high while both the flag and the enable are set. Software acknowledges an event by writing 1 to the status bit. A write that moves the power state from D3hot to D0 makes the block pulse an internal reset for the rest of the function for one cycle. That pulse has no effect on this register.

Top module: `pm_csr_top`

## Requirements
- R1: After the global reset the register reads 0000h, `pme_out` is 0 and `func_rst` is 0.
- R2: Bits 1:0 hold the power state and can be read and written at offset A4h. The encoding is 00=D0, 01=D1, 10=D2 and 11=D3hot. A write to any other offset changes nothing, and a read at any other offset returns 0000h.
- R3: Bits 14:9 and 7:2 always read 0 and ignore writes.
- R4: `pme_event` sets bit 15 whatever the value of bit 8.
- R5: Writing 1 to bit 15 clears it. Writing 0 to bit 15 leaves it unchanged.
- R6: If a PME event and a write of 1 to bit 15 arrive in the same cycle, bit 15 ends up set.
- R7: `pme_out` is 1 exactly when bit 15 and bit 8 are both 1.
- R8: Bit 8 (PME enable) can be read and written. Only the global reset clears it; the primary reset keeps it.
- R9: The primary reset clears bits 1:0. It clears bit 15 only when bit 8 is 0.
- R10: `func_rst` is high for exactly one cycle, the cycle after a write that changes bits 1:0 from 11 to 00. No other transition raises it, and neither does rewriting the same state.
- R11: The D3hot-to-D0 transition and its pulse leave bits 15 and 8 as they were, and bits 1:0 read the newly written 00.
- R12: Both resets take priority over a write in the same cycle, and the global reset takes priority over the primary reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| glob_rst | input | 1 | Global reset, synchronous, active high |
| bus_rst | input | 1 | Primary bus reset, synchronous, active high |
| wr_en | input | 1 | Write strobe |
| addr | input | 8 | Register offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| pme_event | input | 1 | Event that would signal PME |
| pme_out | output | 1 | PME output |
| func_rst | output | 1 | One-cycle internal function reset |

## Verification
Every pair of old and new power states is swept with the enable at 0 and at 1. This shows that only the 11-to-00 write produces a pulse, and that the sticky bits come through it unchanged. Writing each of the 16 bits on its own checks which bits can be written and which always read zero. The primary reset is applied in all four combinations of enable and status, which shows the conditional survival of bit 15. Writes that arrive together with events, with each reset, or at another offset test the priority and decode rules.

// File: rtl/pm_csr_pkg.sv
package pm_csr_pkg;
  localparam int CSR_W = 16;
  localparam int STS_BIT = 15;
  localparam int EN_BIT = 8;

  typedef enum logic [1:0] {
    PS_D0    = 2'b00,
    PS_D1    = 2'b01,
    PS_D2    = 2'b10,
    PS_D3HOT = 2'b11
  } pstate_e;

  // Assemble the readback word from the live fields; all other bits are zero.
  function automatic logic [CSR_W-1:0] csr_pack(input pstate_e st, input logic en, input logic sts);
    logic [CSR_W-1:0] w;
    w = '0;
    w[1:0] = st;
    w[EN_BIT] = en;
    w[STS_BIT] = sts;
    return w;
  endfunction

  // True only for the leaving-D3hot-into-D0 transition.
  function automatic logic is_d3_exit(input pstate_e old_st, input pstate_e new_st);
    return (old_st == PS_D3HOT) && (new_st == PS_D0);
  endfunction
endpackage

// File: rtl/pm_state_ctl.sv
module pm_state_ctl
  import pm_csr_pkg::*;
(
  input  logic    clk,
  input  logic    glob_rst,
  input  logic    bus_rst,
  input  logic    wr_hit,
  input  pstate_e wr_state,
  output pstate_e state_q,
  output logic    d3_exit_pulse
);
  logic exit_now;
  assign exit_now = wr_hit && is_d3_exit(state_q, wr_state);

  always_ff @(posedge clk) begin
    if (glob_rst || bus_rst) begin
      state_q       <= PS_D0;
      d3_exit_pulse <= 1'b0;
    end else begin
      d3_exit_pulse <= exit_now;
      if (wr_hit) state_q <= wr_state;
    end
  end
endmodule

// File: rtl/pm_event_ctl.sv
module pm_event_ctl (
  input  logic clk,
  input  logic glob_rst,
  input  logic bus_rst,
  input  logic wr_hit,
  input  logic wr_en_bit,
  input  logic wr_sts_bit,
  input  logic pme_event,
  output logic pme_en_q,
  output logic pme_sts_q,
  output logic pme_out
);
  // Enable: global reset domain only.
  always_ff @(posedge clk) begin
    if (glob_rst)    pme_en_q <= 1'b0;
    else if (bus_rst) pme_en_q <= pme_en_q;
    else if (wr_hit) pme_en_q <= wr_en_bit;
  end

  // Status: sticky across the primary reset only while enabled.
  always_ff @(posedge clk) begin
    if (glob_rst)                pme_sts_q <= 1'b0;
    else if (bus_rst)            pme_sts_q <= pme_en_q ? pme_sts_q : 1'b0;
    else if (pme_event)          pme_sts_q <= 1'b1;
    else if (wr_hit && wr_sts_bit) pme_sts_q <= 1'b0;
  end

  assign pme_out = pme_sts_q & pme_en_q;
endmodule

// File: rtl/pm_csr_top.sv
module pm_csr_top
  import pm_csr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CSR_ADDR = 8'hA4
) (
  input  logic              clk,
  input  logic              glob_rst,
  input  logic              bus_rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CSR_W-1:0]  wdata,
  output logic [CSR_W-1:0]  rdata,
  input  logic              pme_event,
  output logic              pme_out,
  output logic              func_rst
);
  logic    addr_hit;
  logic    wr_hit;
  pstate_e pwr_state;
  pstate_e wr_state;
  logic    pme_en;
  logic    pme_sts;
  logic    unused_wdata;

  assign addr_hit     = (addr == CSR_ADDR);
  assign wr_hit       = wr_en && addr_hit;
  assign wr_state     = pstate_e'(wdata[1:0]);
  assign unused_wdata = ^{wdata[14:9], wdata[7:2]};

  pm_state_ctl u_state (
    .clk           (clk),
    .glob_rst      (glob_rst),
    .bus_rst       (bus_rst),
    .wr_hit        (wr_hit),
    .wr_state      (wr_state),
    .state_q       (pwr_state),
    .d3_exit_pulse (func_rst)
  );

  pm_event_ctl u_event (
    .clk        (clk),
    .glob_rst   (glob_rst),
    .bus_rst    (bus_rst),
    .wr_hit     (wr_hit),
    .wr_en_bit  (wdata[EN_BIT]),
    .wr_sts_bit (wdata[STS_BIT]),
    .pme_event  (pme_event),
    .pme_en_q   (pme_en),
    .pme_sts_q  (pme_sts),
    .pme_out    (pme_out)
  );

  assign rdata = addr_hit ? csr_pack(pwr_state, pme_en, pme_sts) : '0;
endmodule

// File: rtl/pm_csr_checker.sv
module pm_csr_checker (
  input logic       clk,
  input logic       glob_rst,
  input logic       bus_rst,
  input logic       wr_hit,
  input logic       wr_sts_bit,
  input logic       pme_event,
  input logic [1:0] pwr_state,
  input logic       pme_en,
  input logic       pme_sts,
  input logic       func_rst
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  assert_glob_clear_R1: assert property (@(posedge clk) disable iff (!armed)
    glob_rst |=> (pwr_state == 2'b00 && !pme_en && !pme_sts && !func_rst));

  assert_event_sets_R4: assert property (@(posedge clk) disable iff (!armed || glob_rst || bus_rst)
    pme_event |=> pme_sts);

  assert_w1c_R5: assert property (@(posedge clk) disable iff (!armed || glob_rst || bus_rst)
    (wr_hit && wr_sts_bit && !pme_event) |=> !pme_sts);

  assert_en_keeps_R8: assert property (@(posedge clk) disable iff (!armed || glob_rst)
    (bus_rst && pme_en) |=> pme_en);

  assert_bus_sts_R9: assert property (@(posedge clk) disable iff (!armed || glob_rst)
    (bus_rst && !pme_en) |=> (!pme_sts && pwr_state == 2'b00));

  assert_pulse_one_R10: assert property (@(posedge clk) disable iff (!armed)
    func_rst |=> !func_rst);

  assert_pulse_cause_R10: assert property (@(posedge clk) disable iff (!armed || glob_rst || bus_rst)
    $rose(func_rst) |-> (pwr_state == 2'b00 && $past(pwr_state) == 2'b11));

  assert_pulse_sticky_R11: assert property (@(posedge clk) disable iff (!armed || glob_rst || bus_rst)
    func_rst |-> (pme_en == $past(pme_en)));
endmodule

bind pm_csr_top pm_csr_checker u_pm_chk (
  .clk        (clk),
  .glob_rst   (glob_rst),
  .bus_rst    (bus_rst),
  .wr_hit     (wr_hit),
  .wr_sts_bit (wdata[15]),
  .pme_event  (pme_event),
  .pwr_state  (pwr_state),
  .pme_en     (pme_en),
  .pme_sts    (pme_sts),
  .func_rst   (func_rst)
);

// File: tb/test_pm_csr_top.sv
module test_pm_csr_top;
  logic        clk = 1'b0;
  logic        glob_rst = 1'b1;
  logic        bus_rst = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'hA4;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        pme_event = 1'b0;
  logic        pme_out;
  logic        func_rst;

  int n_cmp = 0;
  int n_bad = 0;

  // bench model
  int m_state = 0;
  int m_en = 0;
  int m_sts = 0;
  int m_pulse = 0;

  always #5 clk = ~clk;

  pm_csr_top i_pm_csr_top (
    .clk(clk), .glob_rst(glob_rst), .bus_rst(bus_rst), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .pme_event(pme_event),
    .pme_out(pme_out), .func_rst(func_rst)
  );

  task automatic cmp(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one cycle at a negedge, let the posedge capture it, return at the next negedge.
  task automatic step(input bit g, input bit b, input bit we, input logic [7:0] a,
                      input logic [15:0] d, input bit ev);
    @(negedge clk);
    glob_rst = g; bus_rst = b; wr_en = we; addr = a; wdata = d; pme_event = ev;
    @(negedge clk);
    glob_rst = 0; bus_rst = 0; wr_en = 0; addr = 8'hA4; wdata = '0; pme_event = 0;
    if (g) begin
      m_state = 0; m_en = 0; m_sts = 0; m_pulse = 0;
    end else if (b) begin
      m_state = 0; m_pulse = 0;
      if (m_en == 0) m_sts = 0;
    end else begin
      m_pulse = 0;
      if (we && a == 8'hA4) begin
        m_pulse = (m_state == 3 && d[1:0] == 0) ? 1 : 0;
        m_state = d[1:0];
        m_en = d[8];
        if (d[15]) m_sts = 0;
      end
      if (ev) m_sts = 1;
    end
  endtask

  task automatic idle();
    step(0, 0, 0, 8'hA4, 16'h0, 0);
  endtask

  task automatic check_all(input string req);
    cmp(req, rdata, m_sts * 32768 + m_en * 256 + m_state);
    cmp(req, pme_out, m_sts * m_en);
    cmp(req, func_rst, m_pulse);
  endtask

  initial begin
    step(1, 0, 0, 8'hA4, 16'h0, 0);
    check_all("R1 reset");

    // R2/R10/R11: every old/new state pair, enable 0 and 1, status set
    for (int en = 0; en < 2; en++)
      for (int fr = 0; fr < 4; fr++)
        for (int to = 0; to < 4; to++) begin
          step(1, 0, 0, 8'hA4, 16'h0, 0);
          step(0, 0, 1, 8'hA4, 16'(en * 256 + fr), 1);
          check_all("R2 setup");
          step(0, 0, 1, 8'hA4, 16'(en * 256 + to), 0);
          cmp("R10 pulse", func_rst, (fr == 3 && to == 0) ? 1 : 0);
          check_all("R11 after transition");
          idle();
          cmp("R10 single cycle", func_rst, 0);
        end

    // R3: each bit written alone
    for (int b = 0; b < 16; b++) begin
      step(1, 0, 0, 8'hA4, 16'h0, 0);
      step(0, 0, 1, 8'hA4, 16'(1 << b), 0);
      cmp("R3 bit mask", rdata, (b == 0 || b == 1 || b == 8) ? (1 << b) : 0);
    end

    // R2: other offset
    step(1, 0, 0, 8'hA4, 16'h0, 0);
    step(0, 0, 1, 8'hA0, 16'h0103, 0);
    check_all("R2 other offset write");
    step(0, 0, 1, 8'hA4, 16'h0002, 0);
    @(negedge clk); addr = 8'hA5; #1;
    cmp("R2 other offset read", rdata, 0);
    addr = 8'hA4;

    // R4/R7: event with enable low, then enable
    step(1, 0, 0, 8'hA4, 16'h0, 0);
    step(0, 0, 0, 8'hA4, 16'h0, 1);
    check_all("R4 event enable low");
    cmp("R7 out blocked", pme_out, 0);
    step(0, 0, 1, 8'hA4, 16'h0100, 0);
    check_all("R8 enable write");
    cmp("R7 out asserted", pme_out, 1);
    // R5: write 0 keeps, write 1 clears
    step(0, 0, 1, 8'hA4, 16'h0101, 0);
    check_all("R5 write zero");
    step(0, 0, 1, 8'hA4, 16'h8101, 0);
    check_all("R5 write one");
    cmp("R5 out dropped", pme_out, 0);
    // R6: event and clear together
    step(0, 0, 1, 8'hA4, 16'h8100, 1);
    check_all("R6 event wins");
    cmp("R6 status", rdata[15], 1);

    // R9/R8: primary reset over enable x status
    for (int en = 0; en < 2; en++)
      for (int st = 0; st < 2; st++) begin
        step(1, 0, 0, 8'hA4, 16'h0, 0);
        step(0, 0, 1, 8'hA4, 16'(en * 256 + 2), st);
        step(0, 1, 0, 8'hA4, 16'h0, 0);
        check_all("R9 primary reset");
        cmp("R8 enable kept", rdata[8], en);
        cmp("R9 status", rdata[15], en * st);
      end

    // R12: resets beat writes, global beats primary
    step(1, 0, 0, 8'hA4, 16'h0, 0);
    step(0, 0, 1, 8'hA4, 16'h0103, 0);
    step(0, 1, 1, 8'hA4, 16'h0002, 0);
    check_all("R12 primary over write");
    step(0, 0, 1, 8'hA4, 16'h0100, 1);
    step(1, 1, 1, 8'hA4, 16'h0103, 0);
    check_all("R12 global over all");
    cmp("R12 cleared", rdata, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog R1 actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule